// File: doc/BRIEF.md
# Prioritised Active Interrupt Resolver

This block takes three interrupt pending words and names the single interrupt to service next. One word is the summary word; the other two are the full pending words of two 32-line banks. Flat interrupt numbers 0 to 7 are the eight summary-word sources. Numbers 8 to 39 are bank 1 lines 0 to 31, and numbers 40 to 71 are bank 2 lines 0 to 31.

The summary word also carries a copy of eleven chosen bank lines, called shortcut lines. These are resolved before any full bank scan takes place. A full bank scan skips the lines that have shortcuts, so an interrupt can only be reached through one path. The resolution is combinational. An optional output register, selected by a parameter, adds one cycle of latency. The result is a 7-bit number and a valid flag, and an interrupt dispatcher can use it directly.

Top module: `irq_resolver`

## Requirements
- R1: Only summary bits 0 to 20 are considered. Summary bits 21 to 31 never affect the result. When bits 0 to 20 are all zero, the valid flag is low, whatever the bank words hold.
- R2: If any of summary bits 0 to 7 is set, the result is the index of the lowest set bit among them, and this stage beats every later one.
- R3: Otherwise, summary bits 10, 11, 12, 13 and 14 are shortcuts for bank 1 lines 7, 9, 10, 18 and 19. They are tested in that order, and the first set bit gives 8 plus its line number.
- R4: Otherwise, summary bits 15 to 20 are shortcuts for bank 2 lines 21, 22, 23, 24, 25 and 30. They are tested in that order, and the first set bit gives 40 plus its line number. All bank 1 shortcuts win over all bank 2 shortcuts.
- R5: Otherwise, if summary bit 8 is set, the bank 1 word is scanned with lines 7, 9, 10, 18 and 19 forced to zero. The lowest remaining set line n gives 8 plus n.
- R6: Otherwise, if summary bit 9 is set, the bank 2 word is scanned with lines 21 to 25 and 30 forced to zero. The lowest remaining set line n gives 40 plus n. This stage is also reached when bank 1 was flagged but its masked word was empty.
- R7: A summary bit that is set over a bank whose masked word is zero gives no result from that bank. If no other stage hits, the valid flag is low.
- R8: When the valid flag is low, the number output is zero.
- R9: With the output register enabled, the outputs show the combinational result exactly one clock later. Reset drives the valid flag and the number to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| basic_pend | input | 32 | Summary pending word: sources, bank flags, shortcut copies |
| bank1_pend | input | 32 | Bank 1 pending word |
| bank2_pend | input | 32 | Bank 2 pending word |
| irq_num | output | 7 | Flat number of the interrupt to service, zero when invalid |
| irq_valid | output | 1 | High when an interrupt was resolved |

## Verification
Within a single cycle, a shortcut stage and a full bank scan often have set bits at the same time. A summary source can likewise be set together with either of them. The stimulus sets bits for several stages in one word on purpose, for example a bank flag plus a pending word that also holds shortcut lines, or both bank flags with an empty masked bank 1. The result is judged correct only when the stage that ranks higher alone decides the number and the lower stage leaves no trace. The registered instance is checked against the same expectations one clock later, and it is also checked to still hold the previous result before that clock edge.

// File: rtl/irq_resolve_pkg.sv
package irq_resolve_pkg;
  localparam int BANK_W     = 32;
  localparam int BASIC_SRC  = 8;
  localparam int NUM_W      = 7;
  localparam int BASIC_USED = 21;
  localparam int SC1_N      = 5;
  localparam int SC2_N      = 6;
  localparam int SC_N       = SC1_N + SC2_N;
  localparam int SUM1_BIT   = 8;
  localparam int SUM2_BIT   = 9;
  localparam int SC_BASE    = 10;
  localparam int BANK1_BASE = BASIC_SRC;
  localparam int BANK2_BASE = BASIC_SRC + BANK_W;
  localparam int IDX_W      = $clog2(BANK_W);

  typedef struct packed {
    logic             hit;
    logic [NUM_W-1:0] num;
  } pick_t;

  // Bank line served by shortcut slot k (slot order is priority order)
  function automatic logic [IDX_W-1:0] sc_line(input int k);
    case (k)
      0: return IDX_W'(7);
      1: return IDX_W'(9);
      2: return IDX_W'(10);
      3: return IDX_W'(18);
      4: return IDX_W'(19);
      5: return IDX_W'(21);
      6: return IDX_W'(22);
      7: return IDX_W'(23);
      8: return IDX_W'(24);
      9: return IDX_W'(25);
      default: return IDX_W'(30);
    endcase
  endfunction

  function automatic logic [NUM_W-1:0] sc_flat(input int k);
    if (k < SC1_N) return NUM_W'(BANK1_BASE) + NUM_W'(sc_line(k));
    return NUM_W'(BANK2_BASE) + NUM_W'(sc_line(k));
  endfunction

  // Lines of a bank (1 or 2) reachable through a shortcut
  function automatic logic [BANK_W-1:0] sc_mask(input int bank);
    logic [BANK_W-1:0] m = '0;
    for (int k = 0; k < SC_N; k++) begin
      if ((bank == 1 && k < SC1_N) || (bank == 2 && k >= SC1_N))
        m[sc_line(k)] = 1'b1;
    end
    return m;
  endfunction

  // Index of lowest set bit; zero when none
  function automatic logic [IDX_W-1:0] low_idx(input logic [BANK_W-1:0] v);
    logic [IDX_W-1:0] r = '0;
    for (int i = BANK_W - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_basic_pick.sv
module irq_basic_pick
  import irq_resolve_pkg::*;
#(
  parameter int SRC_N = BASIC_SRC
) (
  input  logic [SRC_N-1:0] src,
  output pick_t            pick
);
  always_comb begin
    pick.hit = |src;
    pick.num = NUM_W'(low_idx(BANK_W'(src)));
  end
endmodule

// File: rtl/irq_shortcut_pick.sv
module irq_shortcut_pick
  import irq_resolve_pkg::*;
(
  input  logic [SC_N-1:0] sc,
  output pick_t           pick
);
  logic [NUM_W-1:0] flat [SC_N];

  for (genvar k = 0; k < SC_N; k++) begin : g_flat
    assign flat[k] = sc_flat(k);
  end

  always_comb begin
    pick.hit = |sc;
    pick.num = '0;
    for (int k = SC_N - 1; k >= 0; k--) begin
      if (sc[k]) pick.num = flat[k];
    end
  end
endmodule

// File: rtl/irq_bank_scan.sv
module irq_bank_scan
  import irq_resolve_pkg::*;
#(
  parameter int BANK_SEL = 1,
  parameter int BASE     = BANK1_BASE
) (
  input  logic              flagged,
  input  logic [BANK_W-1:0] pend,
  output pick_t             pick
);
  localparam logic [BANK_W-1:0] SKIP = sc_mask(BANK_SEL);

  logic [BANK_W-1:0] masked;

  always_comb begin
    masked   = pend & ~SKIP;
    pick.hit = flagged && (|masked);
    pick.num = pick.hit ? (NUM_W'(BASE) + NUM_W'(low_idx(masked))) : '0;
  end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_resolve_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] basic_pend,
  input  logic [BANK_W-1:0] bank1_pend,
  input  logic [BANK_W-1:0] bank2_pend,
  output logic [NUM_W-1:0]  irq_num,
  output logic              irq_valid
);
  pick_t basic_pk, sc_pk, b1_pk, b2_pk;

  // Named stage selections, brought out for the checker
  logic             sel_basic, sel_sc, sel_b1, sel_b2;
  logic             res_valid;
  logic [NUM_W-1:0] res_num;

  irq_basic_pick #(.SRC_N(BASIC_SRC)) u_basic (
    .src  (basic_pend[BASIC_SRC-1:0]),
    .pick (basic_pk)
  );

  irq_shortcut_pick u_sc (
    .sc   (basic_pend[SC_BASE +: SC_N]),
    .pick (sc_pk)
  );

  irq_bank_scan #(.BANK_SEL(1), .BASE(BANK1_BASE)) u_b1 (
    .flagged (basic_pend[SUM1_BIT]),
    .pend    (bank1_pend),
    .pick    (b1_pk)
  );

  irq_bank_scan #(.BANK_SEL(2), .BASE(BANK2_BASE)) u_b2 (
    .flagged (basic_pend[SUM2_BIT]),
    .pend    (bank2_pend),
    .pick    (b2_pk)
  );

  always_comb begin
    sel_basic = basic_pk.hit;
    sel_sc    = !basic_pk.hit && sc_pk.hit;
    sel_b1    = !basic_pk.hit && !sc_pk.hit && b1_pk.hit;
    sel_b2    = !basic_pk.hit && !sc_pk.hit && !b1_pk.hit && b2_pk.hit;
    res_valid = sel_basic | sel_sc | sel_b1 | sel_b2;
    unique case (1'b1)
      sel_basic: res_num = basic_pk.num;
      sel_sc:    res_num = sc_pk.num;
      sel_b1:    res_num = b1_pk.num;
      sel_b2:    res_num = b2_pk.num;
      default:   res_num = '0;
    endcase
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_valid <= 1'b0;
        irq_num   <= '0;
      end else begin
        irq_valid <= res_valid;
        irq_num   <= res_num;
      end
    end
  end else begin : g_comb
    assign irq_valid = res_valid;
    assign irq_num   = res_num;
  end
endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk
  import irq_resolve_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BANK_W-1:0] basic_pend,
  input logic [NUM_W-1:0]  irq_num,
  input logic              irq_valid,
  input logic              sel_basic,
  input logic              sel_sc,
  input logic              sel_b1,
  input logic              sel_b2,
  input logic              res_valid,
  input logic [NUM_W-1:0]  res_num
);
  localparam logic [BANK_W-1:0] SKIP1 = sc_mask(1);
  localparam logic [BANK_W-1:0] SKIP2 = sc_mask(2);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1
  idle_word_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (basic_pend[BASIC_USED-1:0] == '0) |-> !res_valid);

  // R2
  basic_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_basic |-> (res_num < NUM_W'(BASIC_SRC)));

  // R3 R4 R5 R6
  single_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_basic, sel_sc, sel_b1, sel_b2}));

  // R5
  bank1_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_b1 |-> (res_num >= NUM_W'(BANK1_BASE)) && (res_num < NUM_W'(BANK2_BASE))
               && !SKIP1[IDX_W'(res_num - NUM_W'(BANK1_BASE))]);

  // R6
  bank2_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_b2 |-> (res_num >= NUM_W'(BANK2_BASE))
               && !SKIP2[IDX_W'(res_num - NUM_W'(BANK2_BASE))]);

  // R8
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_num == '0));

  if (OUT_REG) begin : g_lat
    // R9
    one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (irq_valid == $past(res_valid)) && (irq_num == $past(res_num)));
  end
endmodule

bind irq_resolver irq_resolver_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .basic_pend (basic_pend),
  .irq_num    (irq_num),
  .irq_valid  (irq_valid),
  .sel_basic  (sel_basic),
  .sel_sc     (sel_sc),
  .sel_b1     (sel_b1),
  .sel_b2     (sel_b2),
  .res_valid  (res_valid),
  .res_num    (res_num)
);

// File: tb/irq_resolver_bench.sv
module irq_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] basic_pend = '0;
  logic [31:0] bank1_pend = '0;
  logic [31:0] bank2_pend = '0;
  logic [6:0]  r_num, c_num;
  logic        r_valid, c_valid;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  irq_resolver #(.OUT_REG(1'b1)) u_irq_resolver (
    .clk(clk), .rst_n(rst_n), .basic_pend(basic_pend), .bank1_pend(bank1_pend),
    .bank2_pend(bank2_pend), .irq_num(r_num), .irq_valid(r_valid)
  );

  irq_resolver #(.OUT_REG(1'b0)) u_irq_resolver_comb (
    .clk(clk), .rst_n(rst_n), .basic_pend(basic_pend), .bank1_pend(bank1_pend),
    .bank2_pend(bank2_pend), .irq_num(c_num), .irq_valid(c_valid)
  );

  typedef struct packed {
    logic [31:0] b;
    logic [31:0] b1;
    logic [31:0] b2;
    logic        v;
    logic [6:0]  n;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 7'd0,  4'd1}, // R1 idle
    '{32'hFFE0_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 7'd0,  4'd1}, // R1 upper bits ignored
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 7'd0,  4'd1}, // R1 banks without flags
    '{32'h0000_0024, 32'h0000_0000, 32'h0000_0000, 1'b1, 7'd2,  4'd2}, // R2 lowest source
    '{32'h0000_0401, 32'h0000_0000, 32'h0000_0000, 1'b1, 7'd0,  4'd2}, // R2 beats shortcut
    '{32'h0000_0102, 32'h0000_0001, 32'h0000_0000, 1'b1, 7'd1,  4'd2}, // R2 beats bank scan
    '{32'h0000_1800, 32'h0000_0000, 32'h0000_0000, 1'b1, 7'd17, 4'd3}, // R3 line 9 before 10
    '{32'h0000_0400, 32'h0000_0000, 32'h0000_0000, 1'b1, 7'd15, 4'd3}, // R3 line 7
    '{32'h0000_C000, 32'h0000_0000, 32'h0000_0000, 1'b1, 7'd27, 4'd4}, // R4 bank1 shortcut first
    '{32'h0010_8000, 32'h0000_0000, 32'h0000_0000, 1'b1, 7'd61, 4'd4}, // R4 line 21 before 30
    '{32'h0010_0000, 32'h0000_0000, 32'h0000_0000, 1'b1, 7'd70, 4'd4}, // R4 line 30
    '{32'h0000_0100, 32'h0000_1280, 32'h0000_0000, 1'b1, 7'd20, 4'd5}, // R5 shortcut lines skipped
    '{32'h0000_0300, 32'h8000_0000, 32'h0000_0001, 1'b1, 7'd39, 4'd5}, // R5 bank1 before bank2
    '{32'h0000_0200, 32'h8020_0000, 32'h0000_0000, 1'b0, 7'd0,  4'd7}, // R7 bank2 word empty
    '{32'h0000_0200, 32'h0000_0000, 32'h8020_0000, 1'b1, 7'd71, 4'd6}, // R6 line 31
    '{32'h0000_0300, 32'h000C_0680, 32'h0000_0008, 1'b1, 7'd43, 4'd6}, // R6 after empty bank1
    '{32'h0000_0300, 32'h000C_0680, 32'h43E0_0000, 1'b0, 7'd0,  4'd7}  // R7 both masked empty
  };

  task automatic check(input string what, input int rq, input logic av, input logic [6:0] an,
                       input logic ev, input logic [6:0] en);
    checks++;
    if (av !== ev || an !== en) begin
      fails++;
      $display("FAIL R%0d %s: got valid=%0b num=%0d, expected valid=%0b num=%0d",
               rq, what, av, an, ev, en);
    end
  endtask

  initial begin
    logic       pv;
    logic [6:0] pn;
    pv = 1'b0;
    pn = '0;
    repeat (3) @(negedge clk);
    // R9 reset state of the registered outputs
    check("reset state", 9, r_valid, r_num, 1'b0, 7'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("idle after reset", 9, r_valid, r_num, 1'b0, 7'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      basic_pend = VECS[i].b;
      bank1_pend = VECS[i].b1;
      bank2_pend = VECS[i].b2;
      #1;
      // R8 is covered by each invalid row expecting num zero
      check("combinational", VECS[i].rq, c_valid, c_num, VECS[i].v, VECS[i].n);
      check("registered holds prior (R9)", 9, r_valid, r_num, pv, pn);
      @(posedge clk);
      #1;
      check("registered one cycle later", VECS[i].rq, r_valid, r_num, VECS[i].v, VECS[i].n);
      pv = VECS[i].v;
      pn = VECS[i].n;
    end

    // R8 invalid output reads zero number while banks are busy
    @(negedge clk);
    basic_pend = 32'h0000_0100;
    bank1_pend = 32'h000C_0680;
    bank2_pend = 32'hFFFF_FFFF;
    #1;
    check("R8 zero number when invalid", 8, c_valid, c_num, 1'b0, 7'd0);

    // R9 reset clears a valid registered result
    @(negedge clk);
    basic_pend = 32'h0000_0080;
    @(posedge clk);
    #1;
    check("R9 captured before reset", 9, r_valid, r_num, 1'b1, 7'd7);
    rst_n = 1'b0;
    #1;
    check("R9 reset clears", 9, r_valid, r_num, 1'b0, 7'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R9 resumes after reset", 9, r_valid, r_num, 1'b1, 7'd7);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL R9 watchdog expired: got running, expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule